// File: doc/BRIEF.md
# Packed-Decimal Accumulator Control Unit

An 8-bit accumulator, together with the control logic that changes its contents. There is no adder and no logic operation against a second operand. Each operation works on the accumulator alone. It can count up or down, either as a plain binary byte or as two packed decimal digits. It can also invert the byte, zero it, shift it one place either way, or force a single bit high or low. Two status outputs are kept: a zero indication and a carry/borrow flag.

An operation code and a bit index are presented with an enable. The result is written on the next rising clock edge, so every operation takes one cycle. When the enable is low, or the code is not assigned, the accumulator and the flag keep their values. A single counting datapath serves both number systems. Each digit detects its own end value (15 or 9 counting up, 0 counting down), and that detection produces the carry into the next digit directly.

Top module: `acu_core`

## Requirements
- R1: While rst_ni is low, acc_o is 0x00, carry_o is 0 and zero_o is 1.
- R2: With op_valid_i low, or with op_i in 0xA..0xF, neither acc_o nor carry_o changes at the clock edge.
- R3: Code 0x0 increments and code 0x1 decrements acc_o modulo 256. carry_o becomes 1 exactly when the step wraps (0xFF up or 0x00 down); otherwise it becomes 0.
- R4: Code 0x2 counts acc_o up as two BCD digits. A digit at 9 becomes 0 and carries into the upper digit. 0x99 becomes 0x00 with carry_o = 1, and carry_o is 0 for any other start value.
- R5: Code 0x3 counts acc_o down as two BCD digits. A digit at 0 becomes 9 and borrows from the upper digit. 0x00 becomes 0x99 with carry_o = 1, and carry_o is 0 for any other start value.
- R6: carry_o is written only by codes 0x0..0x3; every other operation leaves it unchanged.
- R7: Code 0x4 inverts every bit of acc_o. Code 0x5 sets acc_o to 0x00.
- R8: Code 0x6 shifts acc_o one place toward bit 7, with 0 entering bit 0 and bit 7 lost. Code 0x7 shifts one place toward bit 0, with 0 entering bit 7.
- R9: Code 0x8 sets, and code 0x9 clears, the bit of acc_o selected by bit_idx_i (0 = LSB). All other bits keep their values.
- R10: zero_o is 1 exactly when acc_o equals 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Execute the presented operation at this edge |
| op_i | input | 4 | Operation code |
| bit_idx_i | input | 3 | Bit selected by the set/clear operations |
| acc_o | output | 8 | Accumulator contents |
| zero_o | output | 1 | Accumulator equals zero |
| carry_o | output | 1 | Carry or borrow from the last counting operation |

## Verification
A wrong digit-end detection or a broken carry skip shows on acc_o in the cycle right after the counting operation. It appears either as a non-decimal nibble (0xA, 0xF) or as an upper digit that failed to move. A carry flag written by the wrong operation stays wrong until the next counting operation, so the bench compares carry_o after every single operation, and not only after counts. Every binary start value and every valid two-digit decimal value is swept in both directions. A stale or misdecoded zero indication therefore appears immediately next to the accumulator value it contradicts.

// File: rtl/acu_pkg.sv
package acu_pkg;
  localparam int unsigned DIG_W = 4;

  typedef enum logic [3:0] {
    OP_INC_BIN = 4'h0,
    OP_DEC_BIN = 4'h1,
    OP_INC_BCD = 4'h2,
    OP_DEC_BCD = 4'h3,
    OP_CPL     = 4'h4,
    OP_CLR     = 4'h5,
    OP_SHL     = 4'h6,
    OP_SHR     = 4'h7,
    OP_SETB    = 4'h8,
    OP_CLRB    = 4'h9
  } op_e;

  typedef struct packed {
    logic acc_we;
    logic cy_we;
    logic use_step;
    logic dec;
    logic bcd;
  } ctl_t;
endpackage

// File: rtl/acu_decode.sv
module acu_decode
  import acu_pkg::*;
(
  input  logic       valid_i,
  input  logic [3:0] op_i,
  output ctl_t       ctl_o
);
  logic known;
  logic step;

  assign known = (op_i <= 4'h9);
  // codes 0..3 are the counting group: bit0 = direction, bit1 = decimal
  assign step  = (op_i[3:2] == 2'b00);

  always_comb begin
    ctl_o          = '0;
    ctl_o.acc_we   = valid_i & known;
    ctl_o.cy_we    = valid_i & step;
    ctl_o.use_step = step;
    ctl_o.dec      = op_i[0];
    ctl_o.bcd      = op_i[1];
  end
endmodule

// File: rtl/acu_stepper.sv
module acu_stepper
  import acu_pkg::*;
#(
  parameter int unsigned NDIG = 2,
  localparam int unsigned W   = NDIG * DIG_W
) (
  input  logic [W-1:0] acc_i,
  input  logic         dec_i,
  input  logic         bcd_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  logic [NDIG:0] cy;
  assign cy[0] = 1'b1;

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    logic [DIG_W-1:0] nib;
    logic [DIG_W-1:0] rip;
    logic [DIG_W:0]   k;
    logic             term;
    logic             wrap_bcd;

    assign nib  = acc_i[d*DIG_W +: DIG_W];
    assign k[0] = cy[d];

    // half-adder slices: toggle on incoming carry/borrow
    for (genvar b = 0; b < DIG_W; b++) begin : g_bit
      assign k[b+1]  = k[b] & (nib[b] ^ dec_i);
      assign rip[b]  = nib[b] ^ k[b];
    end

    // digit end value: 0 going down, 9 or 15 going up
    always_comb begin
      if (dec_i)      term = (nib == '0);
      else if (bcd_i) term = (nib == DIG_W'(9));
      else            term = (nib == '1);
    end

    assign wrap_bcd = bcd_i & cy[d] & term;
    // carry skip: next digit sees carry from end detect, not from slice ripple
    assign cy[d+1]  = cy[d] & term;

    always_comb begin
      if (wrap_bcd) res_o[d*DIG_W +: DIG_W] = dec_i ? DIG_W'(9) : '0;
      else          res_o[d*DIG_W +: DIG_W] = rip;
    end
  end

  assign cout_o = cy[NDIG];
endmodule

// File: rtl/acu_shaper.sv
module acu_shaper
  import acu_pkg::*;
#(
  parameter int unsigned W     = 8,
  localparam int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     acc_i,
  input  logic [3:0]       op_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [W-1:0]     res_o
);
  logic [W-1:0] one_hot;
  assign one_hot = W'(1) << idx_i;

  always_comb begin
    unique case (op_e'(op_i))
      OP_CPL:  res_o = ~acc_i;
      OP_CLR:  res_o = '0;
      OP_SHL:  res_o = {acc_i[W-2:0], 1'b0};
      OP_SHR:  res_o = {1'b0, acc_i[W-1:1]};
      OP_SETB: res_o = acc_i | one_hot;
      OP_CLRB: res_o = acc_i & ~one_hot;
      default: res_o = acc_i;
    endcase
  end
endmodule

// File: rtl/acu_core.sv
module acu_core
  import acu_pkg::*;
#(
  parameter int unsigned NDIG  = 2,
  localparam int unsigned W     = NDIG * DIG_W,
  localparam int unsigned IDX_W = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [3:0]       op_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  output logic [W-1:0]     acc_o,
  output logic             zero_o,
  output logic             carry_o
);
  ctl_t         ctl;
  logic [W-1:0] acc_q, step_res, shape_res, acc_d;
  logic         cy_q, step_cy;

  acu_decode u_dec (
    .valid_i (op_valid_i),
    .op_i    (op_i),
    .ctl_o   (ctl)
  );

  acu_stepper #(.NDIG(NDIG)) u_step (
    .acc_i  (acc_q),
    .dec_i  (ctl.dec),
    .bcd_i  (ctl.bcd),
    .res_o  (step_res),
    .cout_o (step_cy)
  );

  acu_shaper #(.W(W)) u_shape (
    .acc_i (acc_q),
    .op_i  (op_i),
    .idx_i (bit_idx_i),
    .res_o (shape_res)
  );

  assign acc_d = ctl.use_step ? step_res : shape_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
    end else begin
      if (ctl.acc_we) acc_q <= acc_d;
      if (ctl.cy_we)  cy_q  <= step_cy;
    end
  end

  assign acc_o   = acc_q;
  assign zero_o  = (acc_q == '0);
  assign carry_o = cy_q;
endmodule

// File: rtl/acu_chk.sv
module acu_chk
  import acu_pkg::*;
#(
  parameter int unsigned NDIG  = 2,
  localparam int unsigned W     = NDIG * DIG_W,
  localparam int unsigned IDX_W = $clog2(W)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             op_valid_i,
  input logic [3:0]       op_i,
  input logic [IDX_W-1:0] bit_idx_i,
  input logic [W-1:0]     acc_o,
  input logic             zero_o,
  input logic             carry_o
);
  logic idle;
  assign idle = !op_valid_i || (op_i > 4'h9);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> $stable(acc_o) && $stable(carry_o));

  p_inc_bin_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 4'h0) |=>
      (acc_o == W'($past(acc_o) + W'(1))) && (carry_o == ($past(acc_o) == '1)));

  p_dec_bin_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 4'h1) |=>
      (acc_o == W'($past(acc_o) - W'(1))) && (carry_o == ($past(acc_o) == '0)));

  p_cy_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i[3:2] != 2'b00) |=> $stable(carry_o));

  p_cpl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 4'h4) |=> acc_o == ~$past(acc_o));

  p_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 4'h5) |=> zero_o);

  p_shr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 4'h7) |=> acc_o == ($past(acc_o) >> 1));

  p_setb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 4'h8) |=>
      acc_o == ($past(acc_o) | (W'(1) << $past(bit_idx_i))));

  p_clrb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 4'h9) |=>
      acc_o == ($past(acc_o) & ~(W'(1) << $past(bit_idx_i))));
endmodule

bind acu_core acu_chk #(.NDIG(NDIG)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .op_i       (op_i),
  .bit_idx_i  (bit_idx_i),
  .acc_o      (acc_o),
  .zero_o     (zero_o),
  .carry_o    (carry_o)
);

// File: tb/sim_acu_core.sv
module sim_acu_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [3:0] op = 4'h0;
  logic [2:0] idx = 3'd0;
  logic [7:0] acc;
  logic       zero, carry;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_acc = 8'h00;
  logic       m_cy  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acu_core u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .op_valid_i (valid),
    .op_i       (op),
    .bit_idx_i  (idx),
    .acc_o      (acc),
    .zero_o     (zero),
    .carry_o    (carry)
  );

  function automatic int to_dec(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] from_dec(input int d);
    return {4'(d / 10), 4'(d % 10)};
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (acc !== m_acc || carry !== m_cy || zero !== (m_acc == 8'h00)) begin
      fails++;
      $display("FAIL %s: acc=%02h carry=%0b zero=%0b expected acc=%02h carry=%0b zero=%0b",
               tag, acc, carry, zero, m_acc, m_cy, (m_acc == 8'h00));
    end
  endtask

  // drive at negedge, edge captures, check at following negedge
  task automatic apply(input logic en, input logic [3:0] o, input logic [2:0] i,
                       input string tag);
    int d;
    @(negedge clk);
    valid = en; op = o; idx = i;
    if (en) begin
      case (o)
        4'h0: begin m_cy = (m_acc == 8'hFF); m_acc = m_acc + 8'd1; end
        4'h1: begin m_cy = (m_acc == 8'h00); m_acc = m_acc - 8'd1; end
        4'h2: begin
          d = to_dec(m_acc);
          m_cy = (d == 99);
          m_acc = from_dec((d + 1) % 100);
        end
        4'h3: begin
          d = to_dec(m_acc);
          m_cy = (d == 0);
          m_acc = from_dec((d + 99) % 100);
        end
        4'h4: m_acc = ~m_acc;
        4'h5: m_acc = 8'h00;
        4'h6: m_acc = {m_acc[6:0], 1'b0};
        4'h7: m_acc = {1'b0, m_acc[7:1]};
        4'h8: m_acc[i] = 1'b1;
        4'h9: m_acc[i] = 1'b0;
        default: ;
      endcase
    end
    @(negedge clk);
    valid = 1'b0;
    compare(tag);
  endtask

  task automatic load(input logic [7:0] v);
    apply(1'b1, 4'h5, 3'd0, "R7 clear");
    for (int b = 0; b < 8; b++)
      if (v[b]) apply(1'b1, 4'h8, 3'(b), "R9 set bit");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    compare("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R3 binary up/down over every start value
    for (int v = 0; v < 256; v++) begin
      load(8'(v)); apply(1'b1, 4'h0, 3'd0, "R3 inc bin");
      load(8'(v)); apply(1'b1, 4'h1, 3'd0, "R3 dec bin");
    end

    // R4 / R5 decimal up/down over every valid value
    for (int d = 0; d < 100; d++) begin
      load(from_dec(d)); apply(1'b1, 4'h2, 3'd0, "R4 inc bcd");
      load(from_dec(d)); apply(1'b1, 4'h3, 3'd0, "R5 dec bcd");
    end

    // R7, R8 over every value
    for (int v = 0; v < 256; v++) begin
      load(8'(v));
      apply(1'b1, 4'h4, 3'd0, "R7 complement");
      apply(1'b1, 4'h6, 3'd0, "R8 shift left");
      load(8'(v));
      apply(1'b1, 4'h7, 3'd0, "R8 shift right");
    end

    // R9 every index on a few patterns
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < 8; b++) begin
        load(p == 0 ? 8'h00 : p == 1 ? 8'hFF : p == 2 ? 8'hA5 : 8'h5A);
        apply(1'b1, 4'h8, 3'(b), "R9 set one");
        apply(1'b1, 4'h9, 3'(b), "R9 clear one");
      end
    end

    // R6 carry survives non-counting operations
    load(8'hFF);
    apply(1'b1, 4'h0, 3'd0, "R6 carry set by wrap");
    apply(1'b1, 4'h4, 3'd0, "R6 carry kept by complement");
    apply(1'b1, 4'h6, 3'd0, "R6 carry kept by shift");
    apply(1'b1, 4'h9, 3'd3, "R6 carry kept by clear bit");
    apply(1'b1, 4'h0, 3'd0, "R6 carry cleared by next step");

    // R10 zero reached by counting down
    load(8'h01);
    apply(1'b1, 4'h1, 3'd0, "R10 zero after dec");
    apply(1'b1, 4'h3, 3'd0, "R10 leave zero by bcd dec");

    // R2 disabled and unassigned codes
    load(8'h3C);
    for (int o = 0; o < 16; o++)
      apply(1'b0, 4'(o), 3'(o), "R2 hold disabled");
    for (int o = 10; o < 16; o++)
      apply(1'b1, 4'(o), 3'(o), "R2 hold unassigned");

    // R1 reset mid-run
    load(8'h77);
    @(negedge clk);
    rst_n = 1'b0;
    m_acc = 8'h00; m_cy = 1'b0;
    #1;
    compare("R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule